// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller for a successive-approximation analog-to-digital converter that converts one channel at a time. Software drives it through a register-style write port. Each write carries three fields: an enable bit, a start bit and a channel number. The controller has three states: stopped, standby and converting. Software enables the converter, then sets the start bit to convert the selected channel. The start bit clears itself when the result is ready. Writing the start bit back to zero cancels a conversion that is still running.

The analog parts sit outside the block and appear here only as digital ports. These are the input multiplexer (the `sample_chan` select), the sample-and-hold (the `sample_hold` strobe), the DAC (the `dac_code` output) and the comparator (the `cmp_ge` input). A finished conversion is stored in a result register, tagged with the channel it came from, and announced by a one-cycle interrupt pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the block is stopped. `stat_enable`, `stat_start`, `stat_busy`, `sample_hold` and `eoc_irq` are 0, and `result`, `result_chan` and `dac_code` are all zeros.
- R2: A write with `cfg_enable`=1 while stopped moves the block to standby (`stat_enable`=1). No conversion begins, even when `cfg_start` is also 1 in that write.
- R3: A write with `cfg_start`=1 while stopped is ignored. `stat_busy` and `stat_start` stay 0 and `dac_code` stays 0.
- R4: A write with `cfg_enable`=1 and `cfg_start`=1 while in standby starts a conversion. From the next cycle, `stat_busy` and `stat_start` are 1, `sample_chan` equals the `cfg_chan` of that write, and `sample_hold` is 1 with `dac_code` at 0 for SAMPLE_CYC cycles (default 4).
- R5: After sampling, the block resolves RES_BITS bits (default 10), most significant first, one per cycle. In each bit cycle `dac_code` is the bits kept so far with the trial bit set. The trial bit is kept when `cmp_ge` is 1 in that cycle.
- R6: SAMPLE_CYC+RES_BITS cycles after the start write, `stat_busy` and `stat_start` return to 0 and the block is back in standby. In that same cycle `result` holds the resolved code and `eoc_irq` is 1 for exactly one cycle.
- R7: A write with `cfg_enable`=1 and `cfg_start`=0 during a conversion aborts it. From the next cycle `stat_busy` is 0 and the block is in standby. No `eoc_irq` follows, and `result` and `result_chan` are unchanged.
- R8: A write with `cfg_enable`=0 while in standby returns the block to stopped (`stat_enable`=0).
- R9: A write with `cfg_enable`=0 and `cfg_start`=1, in standby or during a conversion, acts as a disable. The block goes to stopped, any conversion is dropped without `eoc_irq`, and `stat_start` reads 0.
- R10: Every write updates `stat_chan`. The channel used for a conversion is the one captured at its start. `sample_chan` and the resulting `result_chan` ignore channel writes made while the conversion runs.
- R11: `result` and `result_chan` change only in the cycle where `eoc_irq` is 1. Rewriting the channel leaves the previous result in place until a new conversion finishes.
- R12: A write with `cfg_enable`=1 and `cfg_start`=1 during a conversion neither restarts nor aborts it. The conversion completes on its original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control fields |
| cfg_enable | input | 1 | Enable bit written |
| cfg_start | input | 1 | Start bit written |
| cfg_chan | input | CH_W | Channel number written |
| stat_enable | output | 1 | Enable readback (0 only while stopped) |
| stat_start | output | 1 | Start bit readback, cleared by hardware |
| stat_busy | output | 1 | Conversion in progress |
| stat_chan | output | CH_W | Channel field readback |
| sample_hold | output | 1 | Sampling phase strobe to the sample-and-hold |
| sample_chan | output | CH_W | Channel select to the input multiplexer |
| dac_code | output | RES_BITS | Trial code to the DAC |
| cmp_ge | input | 1 | Comparator: input is at or above the DAC level |
| result | output | RES_BITS | Last completed conversion |
| result_chan | output | CH_W | Channel of the last completed conversion |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The assertions assume that `cmp_ge` is a function of the selected channel and the current `dac_code`, and that writes arrive only as single-cycle `cfg_wr` strobes. The bench meets both. Its comparator is a combinational compare of a fixed per-channel level against `dac_code`, and every write task raises `cfg_wr` for exactly one clock. The stimulus also exercises the full-scale, zero and mid-scale edges of the comparator. It issues conflicting writes (start while stopped, start with enable cleared, a start rewrite during a conversion) only at points where a reference model tracks the expected state on every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_OFF  = 2'd0,
      SEQ_IDLE = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_t;

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       wr_enable,
   input  logic       wr_start,
   input  logic       sar_done,
   output seq_state_t state,
   output logic       sar_load,
   output logic       sar_abort,
   output logic       commit
);

   seq_state_t state_nxt;

   always_comb begin
      state_nxt = state;
      sar_load  = 1'b0;
      sar_abort = 1'b0;
      commit    = 1'b0;
      unique case (state)
         SEQ_OFF: begin
            // start requests are dropped here; only enable matters
            if (wr && wr_enable) state_nxt = SEQ_IDLE;
         end
         SEQ_IDLE: begin
            if (wr) begin
               if (!wr_enable) begin
                  state_nxt = SEQ_OFF;
               end else if (wr_start) begin
                  state_nxt = SEQ_RUN;
                  sar_load  = 1'b1;
               end
            end
         end
         SEQ_RUN: begin
            if (wr && !wr_enable) begin
               state_nxt = SEQ_OFF;
               sar_abort = 1'b1;
            end else if (wr && !wr_start) begin
               state_nxt = SEQ_IDLE;
               sar_abort = 1'b1;
            end else if (sar_done) begin
               state_nxt = SEQ_IDLE;
               commit    = 1'b1;
            end
         end
         default: state_nxt = SEQ_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_OFF;
      else        state <= state_nxt;
   end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
   parameter int RES_BITS   = 10,
   parameter int SAMPLE_CYC = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                abort,
   input  logic                cmp_ge,
   output logic                in_sample,
   output logic [RES_BITS-1:0] dac_code,
   output logic                done,
   output logic [RES_BITS-1:0] final_code
);

   localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

   logic                active;
   logic [IDX_W-1:0]    bit_idx;
   logic [RES_BITS-1:0] acc;
   logic [RES_BITS-1:0] bit_mask;
   logic [RES_BITS-1:0] trial;
   logic                decide;

   generate
      if (SAMPLE_CYC > 1) begin : g_samp_cnt
         localparam int SW = $clog2(SAMPLE_CYC + 1);
         localparam logic [SW-1:0] SAMP_END = SW'(SAMPLE_CYC);
         logic [SW-1:0] samp_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               samp_cnt <= '0;
            else if (load)                            samp_cnt <= '0;
            else if (active && samp_cnt != SAMP_END)  samp_cnt <= samp_cnt + 1'b1;
         end
         assign in_sample = active && (samp_cnt != SAMP_END);
      end else begin : g_samp_flag
         logic samp_seen;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      samp_seen <= 1'b0;
            else if (load)   samp_seen <= 1'b0;
            else if (active) samp_seen <= 1'b1;
         end
         assign in_sample = active && !samp_seen;
      end
   endgenerate

   assign bit_mask   = {{(RES_BITS-1){1'b0}}, 1'b1} << bit_idx;
   assign trial      = acc | bit_mask;
   assign decide     = active && !in_sample;
   assign done       = decide && (bit_idx == '0);
   assign final_code = cmp_ge ? trial : acc;
   assign dac_code   = decide ? trial : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         acc     <= '0;
         bit_idx <= '0;
      end else if (load) begin
         active  <= 1'b1;
         acc     <= '0;
         bit_idx <= TOP_IDX;
      end else if (abort) begin
         active  <= 1'b0;
      end else if (decide) begin
         acc <= final_code;
         if (bit_idx == '0) active  <= 1'b0;
         else               bit_idx <= bit_idx - 1'b1;
      end
   end

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
   parameter int RES_BITS = 10,
   parameter int CH_W     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [CH_W-1:0]     wr_chan,
   input  logic                load,
   input  logic                commit,
   input  logic [RES_BITS-1:0] code_in,
   output logic [CH_W-1:0]     chan_field,
   output logic [CH_W-1:0]     conv_chan,
   output logic [RES_BITS-1:0] result,
   output logic [CH_W-1:0]     result_chan,
   output logic                eoc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_field  <= '0;
         conv_chan   <= '0;
         result      <= '0;
         result_chan <= '0;
         eoc         <= 1'b0;
      end else begin
         eoc <= commit;
         if (wr)   chan_field <= wr_chan;
         if (load) conv_chan  <= wr_chan;
         if (commit) begin
            result      <= code_in;
            result_chan <= conv_chan;
         end
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int RES_BITS   = 10,
   parameter int CH_W       = 3,
   parameter int SAMPLE_CYC = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic                cfg_enable,
   input  logic                cfg_start,
   input  logic [CH_W-1:0]     cfg_chan,
   output logic                stat_enable,
   output logic                stat_start,
   output logic                stat_busy,
   output logic [CH_W-1:0]     stat_chan,
   output logic                sample_hold,
   output logic [CH_W-1:0]     sample_chan,
   output logic [RES_BITS-1:0] dac_code,
   input  logic                cmp_ge,
   output logic [RES_BITS-1:0] result,
   output logic [CH_W-1:0]     result_chan,
   output logic                eoc_irq
);

   generate
      if (RES_BITS < 2 || RES_BITS > 16) begin : g_bad_res
         $error("adc_seq_ctrl: RES_BITS must be in 2..16");
      end
      if (CH_W < 1 || CH_W > 8) begin : g_bad_ch
         $error("adc_seq_ctrl: CH_W must be in 1..8");
      end
      if (SAMPLE_CYC < 1 || SAMPLE_CYC > 255) begin : g_bad_samp
         $error("adc_seq_ctrl: SAMPLE_CYC must be in 1..255");
      end
   endgenerate

   seq_state_t          state;
   logic                sar_load;
   logic                sar_abort;
   logic                sar_done;
   logic                commit;
   logic [RES_BITS-1:0] final_code;

   adc_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .wr_enable (cfg_enable),
      .wr_start  (cfg_start),
      .sar_done  (sar_done),
      .state     (state),
      .sar_load  (sar_load),
      .sar_abort (sar_abort),
      .commit    (commit)
   );

   adc_sar_core #(
      .RES_BITS   (RES_BITS),
      .SAMPLE_CYC (SAMPLE_CYC)
   ) u_sar (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (sar_load),
      .abort      (sar_abort),
      .cmp_ge     (cmp_ge),
      .in_sample  (sample_hold),
      .dac_code   (dac_code),
      .done       (sar_done),
      .final_code (final_code)
   );

   adc_result_store #(
      .RES_BITS (RES_BITS),
      .CH_W     (CH_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (cfg_wr),
      .wr_chan     (cfg_chan),
      .load        (sar_load),
      .commit      (commit),
      .code_in     (final_code),
      .chan_field  (stat_chan),
      .conv_chan   (sample_chan),
      .result      (result),
      .result_chan (result_chan),
      .eoc         (eoc_irq)
   );

   assign stat_enable = (state != SEQ_OFF);
   assign stat_start  = (state == SEQ_RUN);
   assign stat_busy   = (state == SEQ_RUN);

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int RES_BITS = 10,
   parameter int CH_W     = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_wr,
   input logic                cfg_enable,
   input logic                cfg_start,
   input logic                stat_enable,
   input logic                stat_start,
   input logic                stat_busy,
   input logic                sample_hold,
   input logic [CH_W-1:0]     sample_chan,
   input logic [RES_BITS-1:0] dac_code,
   input logic [RES_BITS-1:0] result,
   input logic [CH_W-1:0]     result_chan,
   input logic                eoc_irq
);

   assert_stopped_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_enable |-> (!stat_busy && !stat_start && dac_code == '0));

   assert_sample_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_hold |-> (stat_busy && dac_code == '0));

   assert_eoc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_irq |=> !eoc_irq);

   assert_eoc_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_irq |-> ($past(stat_busy) && !stat_busy && stat_enable));

   assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_busy && cfg_wr && cfg_enable && !cfg_start) |=> (!stat_busy && stat_enable && !eoc_irq));

   assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_enable) |=> (!stat_enable && !stat_start && !eoc_irq));

   assert_chan_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_busy && $past(stat_busy)) |-> $stable(sample_chan));

   assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_irq |-> ($stable(result) && $stable(result_chan)));

endmodule

bind adc_seq_ctrl adc_seq_chk #(
   .RES_BITS (RES_BITS),
   .CH_W     (CH_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr      (cfg_wr),
   .cfg_enable  (cfg_enable),
   .cfg_start   (cfg_start),
   .stat_enable (stat_enable),
   .stat_start  (stat_start),
   .stat_busy   (stat_busy),
   .sample_hold (sample_hold),
   .sample_chan (sample_chan),
   .dac_code    (dac_code),
   .result      (result),
   .result_chan (result_chan),
   .eoc_irq     (eoc_irq)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

   localparam int RB = 10;
   localparam int CW = 3;
   localparam int SC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic          cfg_enable = 1'b0;
   logic          cfg_start = 1'b0;
   logic [CW-1:0] cfg_chan = '0;
   logic          stat_enable, stat_start, stat_busy, sample_hold, eoc_irq, cmp_ge;
   logic [CW-1:0] stat_chan, sample_chan, result_chan;
   logic [RB-1:0] dac_code, result;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done_flag = 1'b0;

   int ain [8] = '{10'h2A5, 10'h3FF, 10'h000, 10'h200, 10'h1FF, 10'h155, 10'h0AA, 10'h301};

   always #2.5 clk = ~clk;

   // analog comparator stand-in
   assign cmp_ge = (ain[sample_chan] >= int'(dac_code));

   adc_seq_ctrl #(.RES_BITS(RB), .CH_W(CW), .SAMPLE_CYC(SC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
      .cfg_start(cfg_start), .cfg_chan(cfg_chan), .stat_enable(stat_enable),
      .stat_start(stat_start), .stat_busy(stat_busy), .stat_chan(stat_chan),
      .sample_hold(sample_hold), .sample_chan(sample_chan), .dac_code(dac_code),
      .cmp_ge(cmp_ge), .result(result), .result_chan(result_chan), .eoc_irq(eoc_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: 0 stopped, 1 standby, 2 converting
   int m_state = 0, m_cnt = 0, m_acc = 0, m_result = 0, m_rchan = 0;
   int m_chan = 0, m_cchan = 0, m_eoc = 0;

   function automatic int m_dac();
      if (m_state == 2 && m_cnt >= SC) return m_acc | (1 << (RB - 1 - (m_cnt - SC)));
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_acc = 0; m_result = 0; m_rchan = 0;
         m_chan = 0; m_cchan = 0; m_eoc = 0;
      end else begin
         int nacc;
         int trial;
         bit fin;
         fin = 1'b0;
         nacc = m_acc;
         m_eoc = 0;
         if (m_state == 2 && m_cnt >= SC) begin
            trial = m_dac();
            if (ain[m_cchan] >= trial) nacc = trial;
            if (m_cnt - SC == RB - 1) fin = 1'b1;
         end
         case (m_state)
            0: if (cfg_wr && cfg_enable) m_state = 1;
            1: if (cfg_wr) begin
                  if (!cfg_enable) m_state = 0;
                  else if (cfg_start) begin
                     m_state = 2; m_cnt = 0; m_acc = 0; m_cchan = int'(cfg_chan);
                  end
               end
            default: begin
               if (cfg_wr && !cfg_enable) m_state = 0;
               else if (cfg_wr && !cfg_start) m_state = 1;
               else if (fin) begin
                  m_result = nacc; m_rchan = m_cchan; m_eoc = 1; m_state = 1;
               end else begin
                  m_acc = nacc; m_cnt++;
               end
            end
         endcase
         if (cfg_wr) m_chan = int'(cfg_chan);
      end
      #1;
      if (rst_n && !done_flag) begin
         chk("R2/R8/R9 enable readback", int'(stat_enable), int'(m_state != 0));
         chk("R4/R6/R7 busy", int'(stat_busy), int'(m_state == 2));
         chk("R6 start readback", int'(stat_start), int'(m_state == 2));
         chk("R4 sample strobe", int'(sample_hold), int'(m_state == 2 && m_cnt < SC));
         chk("R5 dac code", int'(dac_code), m_dac());
         chk("R10 sample channel", int'(sample_chan), m_cchan);
         chk("R10 channel field", int'(stat_chan), m_chan);
         chk("R6 eoc pulse", int'(eoc_irq), m_eoc);
         chk("R11 result", int'(result), m_result);
         chk("R11 result channel", int'(result_chan), m_rchan);
      end
   end

   task automatic wr(input bit en, input bit st, input int ch);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_enable = en; cfg_start = st; cfg_chan = CW'(ch);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      while (!done_flag) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 enable", int'(stat_enable), 0);
      chk("R1 busy", int'(stat_busy), 0);
      chk("R1 result", int'(result), 0);
      chk("R1 eoc", int'(eoc_irq), 0);

      // R3 start while stopped
      wr(1'b0, 1'b1, 2);
      chk("R3 busy after start in stop", int'(stat_busy), 0);
      chk("R3 start readback", int'(stat_start), 0);
      idle(2);
      chk("R3 still stopped", int'(stat_enable), 0);

      // R2 enable (with start) from stop
      wr(1'b1, 1'b1, 0);
      chk("R2 enabled", int'(stat_enable), 1);
      chk("R2 no conversion", int'(stat_busy), 0);
      idle(3);
      chk("R2 still idle", int'(stat_busy), 0);

      // R4/R5/R6/R10/R12: convert ch0, meddle mid-way
      wr(1'b1, 1'b1, 0);
      chk("R4 busy", int'(stat_busy), 1);
      chk("R4 sampling", int'(sample_hold), 1);
      wr(1'b1, 1'b1, 5);   // R12 rewrite start, R10 channel change
      chk("R10 field updated", int'(stat_chan), 5);
      chk("R10 conv channel kept", int'(sample_chan), 0);
      idle(12);
      chk("R6 eoc", int'(eoc_irq), 1);
      chk("R6 busy cleared", int'(stat_busy), 0);
      chk("R6 result ch0", int'(result), ain[0]);
      chk("R10 result channel", int'(result_chan), 0);
      chk("R12 no restart", int'(stat_enable), 1);

      // R5 boundary levels
      for (int c = 1; c <= 4; c++) begin
         wr(1'b1, 1'b1, c);
         idle(14);
         chk("R5 result", int'(result), ain[c]);
         chk("R6 eoc each", int'(eoc_irq), 1);
      end

      // R7 abort
      wr(1'b1, 1'b1, 5);
      idle(5);
      wr(1'b1, 1'b0, 5);
      chk("R7 aborted", int'(stat_busy), 0);
      chk("R7 standby", int'(stat_enable), 1);
      idle(12);
      chk("R7 result kept", int'(result), ain[4]);
      chk("R7 no eoc", int'(eoc_irq), 0);

      // R9 start with enable cleared during conversion
      wr(1'b1, 1'b1, 6);
      idle(8);
      wr(1'b0, 1'b1, 6);
      chk("R9 stopped", int'(stat_enable), 0);
      chk("R9 start readback", int'(stat_start), 0);
      idle(10);
      chk("R9 result kept", int'(result), ain[4]);

      // R11 channel rewrite between conversions, R8 disable from standby
      wr(1'b1, 1'b0, 7);
      wr(1'b1, 1'b0, 6);
      chk("R11 previous result", int'(result_chan), 4);
      wr(1'b1, 1'b1, 7);
      idle(14);
      chk("R11 new result", int'(result), ain[7]);
      wr(1'b0, 1'b0, 7);
      chk("R8 stopped", int'(stat_enable), 0);
      idle(3);

      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule